// File: doc/BRIEF.md
# USB Device IN Endpoint Control and Status Register

This block holds the control and status byte for one IN endpoint of a USB device controller. It also keeps a count of the packets that are waiting for transmission. Firmware uses an 8-bit write strobe and data bus, and reads the status back on a continuously driven read bus. Software loads a packet into the endpoint FIFO, then commits it by writing the ready bit. From then on the serial engine reports what happens on the bus: IN tokens, transmitted packets, STALL handshakes and start-of-frame markers.

The block turns those events and the software writes into status flags and control outputs. It owns the data toggle and the stall request. It produces the FIFO pointer reset and the flush strobes, which the FIFO logic uses to discard packets. It raises a one-cycle completion interrupt when a packet has been transmitted. Three mode inputs change its behaviour: isochronous operation, double buffering, and an isochronous hold that keeps a committed packet hidden until the next frame starts.

Every state change takes effect at the clock edge that ends the cycle in which the event or write is presented. The strobe outputs are combinational from the current state and inputs.

Top module: `usb_in_ep_csr`

## Requirements
- R1: After reset the read byte is 0x00. Bits 7 and 6 always read 0, and a write to bit 7 has no effect.
- R2: Writing 1 to bit 6 forces data_toggle_o to 0, and this clear wins over a flip in the same cycle. Each non-isochronous transmit that frees a queued packet flips the toggle. An isochronous transmit leaves the toggle unchanged.
- R3: A stall_sent_i cycle has these effects:
  - fifo_ptr_rst_o is high in that cycle.
  - The queue is emptied, so bit 1 reads 0.
  - Bit 0 (ready) is cleared.
  - Bit 5 (stall-sent flag) is set.
  
  Bit 5 stays set until a write with bit 5 equal to 0. If such a write lands in the same cycle as a stall, the flag stays set.
- R4: Bit 4 (stall request) is a plain read/write bit. stall_req_o equals bit 4 while iso_mode_i is 0 and is forced low while iso_mode_i is 1.
- R5: Writing 1 to bit 3 starts a flush:
  - Bit 3 reads 1 for exactly one cycle.
  - In that cycle flush_o and fifo_ptr_rst_o are high.
  - At the end of that cycle at most one queued packet is removed, and ready is cleared.
  
  A flush write made while a flush is pending is ignored.
- R6: Bit 2 (underrun) is set when, in isochronous mode, in_token_i arrives with no packet queued. It reads 0 whenever iso_mode_i is 0. A write with bit 2 equal to 0 clears it. If that clear lands in the same cycle as a set, the set wins.
- R7: Bit 1 reads 1 exactly when one or more packets are queued.
- R8: Writing 1 to bit 0 commits a packet when the queue holds fewer packets than its capacity: 1 with dbl_buf_i low, 2 with it high. A commit adds a packet and sets ready. A commit into a full queue, or a write of 0 to bit 0, changes nothing.
- R9: A pkt_sent_i cycle with a packet queued removes the oldest packet and clears ready. With double buffering, ready also clears in the cycle after it was set if the queue then has a free slot.
- R10: A commit made while both iso_mode_i and iso_hold_i are high makes bit 0 read 0 until the cycle after the next sof_i.
- R11: irq_o pulses high for one cycle, the cycle after a pkt_sent_i that removed a packet while irq_en_i was high. Flushes and stalls raise no interrupt.
- R12: Hardware wins collisions:
  - A commit in the same cycle as a transmit leaves ready at 0, with the count changed by both.
  - A stall overrides commits and flushes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| in_token_i | input | 1 | IN token received for this endpoint |
| pkt_sent_i | input | 1 | Data packet transmitted (and acknowledged when not isochronous) |
| stall_sent_i | input | 1 | STALL handshake transmitted |
| sof_i | input | 1 | Start of frame received |
| iso_mode_i | input | 1 | Endpoint is isochronous |
| dbl_buf_i | input | 1 | Double buffering enabled |
| iso_hold_i | input | 1 | Hide committed isochronous packets until the next frame |
| irq_en_i | input | 1 | Completion interrupt enable |
| data_toggle_o | output | 1 | Current DATA0/DATA1 toggle |
| stall_req_o | output | 1 | Answer IN tokens with STALL |
| fifo_ptr_rst_o | output | 1 | FIFO pointer reset strobe |
| flush_o | output | 1 | Drop-one-packet strobe |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The following properties are checked on every cycle:
- the unused bits read 0;
- the flush bit always drops after one cycle;
- stall handling: the pointer reset, the flag, and the emptied queue;
- the stall request is masked in isochronous mode;
- the underrun bit is masked outside isochronous mode;
- the toggle clear;
- a ready bit never shows over an empty queue;
- the interrupt is traced back to an enabled transmit.

Other behaviour shows only in the bench scenarios, compared against a queue-based model:
- the slot count reached by mixed sequences of commits, transmits and flushes under each buffering mode;
- the early release of ready under double buffering;
- the hold lifting on start of frame;
- which side wins in each collision.

// File: rtl/usb_in_ep_pkg.sv
`timescale 1ns/1ps
package usb_in_ep_pkg;
  // positions the firmware decodes
  localparam int unsigned BIT_RDY = 0;
  localparam int unsigned BIT_NE  = 1;
  localparam int unsigned BIT_UND = 2;
  localparam int unsigned BIT_FLU = 3;
  localparam int unsigned BIT_SDS = 4;
  localparam int unsigned BIT_STS = 5;
  localparam int unsigned BIT_CLR = 6;

  typedef struct packed {
    logic commit;
    logic flush;
    logic clr_tog;
    logic clr_sts;
    logic clr_und;
    logic sds_wr;
    logic sds_val;
  } sw_cmd_t;
endpackage

// File: rtl/usb_in_ep_slots.sv
`timescale 1ns/1ps
module usb_in_ep_slots #(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned CW = $clog2(NUM_SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dbl_buf_i,
  input  logic          commit_i,
  input  logic          sent_i,
  input  logic          flush_i,
  input  logic          stall_i,
  output logic          commit_ok_o,
  output logic          sent_ok_o,
  output logic          room_o,
  output logic          busy_o
);
  logic [CW-1:0] cnt_q, cnt_d, cap, after_sent;
  logic          flush_ok;

  assign cap         = dbl_buf_i ? CW'(NUM_SLOTS) : CW'(1);
  assign room_o      = cnt_q < cap;
  assign busy_o      = cnt_q != '0;
  assign commit_ok_o = commit_i & room_o;
  assign sent_ok_o   = sent_i & busy_o;
  assign after_sent  = cnt_q - CW'(sent_ok_o);
  assign flush_ok    = flush_i & (after_sent != '0);

  always_comb begin
    if (stall_i) cnt_d = '0;
    else         cnt_d = after_sent - CW'(flush_ok) + CW'(commit_ok_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/usb_in_ep_toggle.sv
`timescale 1ns/1ps
module usb_in_ep_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic flip_i,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tog_o <= 1'b0;
    else if (clr_i)  tog_o <= 1'b0;
    else if (flip_i) tog_o <= ~tog_o;
  end
endmodule

// File: rtl/usb_in_ep_flags.sv
`timescale 1ns/1ps
module usb_in_ep_flags
  import usb_in_ep_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sw_cmd_t cmd_i,
  input  logic    iso_i,
  input  logic    hold_en_i,
  input  logic    token_i,
  input  logic    sof_i,
  input  logic    stall_i,
  input  logic    commit_ok_i,
  input  logic    sent_ok_i,
  input  logic    dbl_room_i,
  input  logic    empty_i,
  output logic    rdy_vis_o,
  output logic    sts_o,
  output logic    sds_o,
  output logic    und_vis_o,
  output logic    flush_o
);
  logic rdy_q, hold_q, und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      hold_q  <= 1'b0;
      sts_o   <= 1'b0;
      sds_o   <= 1'b0;
      und_q   <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      // ready: hardware clears take priority over a commit
      if (stall_i || sent_ok_i || flush_o) rdy_q <= 1'b0;
      else if (commit_ok_i)                rdy_q <= 1'b1;
      else if (dbl_room_i && rdy_q)        rdy_q <= 1'b0;

      if (commit_ok_i && iso_i && hold_en_i) hold_q <= 1'b1;
      else if (sof_i)                        hold_q <= 1'b0;

      if (stall_i)            sts_o <= 1'b1;
      else if (cmd_i.clr_sts) sts_o <= 1'b0;

      if (cmd_i.sds_wr) sds_o <= cmd_i.sds_val;

      if (iso_i && token_i && empty_i) und_q <= 1'b1;
      else if (cmd_i.clr_und)          und_q <= 1'b0;

      // one-cycle pending flush; further requests ignored while pending
      if (flush_o)          flush_o <= 1'b0;
      else if (cmd_i.flush) flush_o <= 1'b1;
    end
  end

  assign rdy_vis_o = rdy_q & ~hold_q;
  assign und_vis_o = und_q & iso_i;
endmodule

// File: rtl/usb_in_ep_csr.sv
`timescale 1ns/1ps
module usb_in_ep_csr
  import usb_in_ep_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       in_token_i,
  input  logic       pkt_sent_i,
  input  logic       stall_sent_i,
  input  logic       sof_i,
  input  logic       iso_mode_i,
  input  logic       dbl_buf_i,
  input  logic       iso_hold_i,
  input  logic       irq_en_i,
  output logic       data_toggle_o,
  output logic       stall_req_o,
  output logic       fifo_ptr_rst_o,
  output logic       flush_o,
  output logic       irq_o
);
  sw_cmd_t cmd;
  logic    commit_ok, sent_ok, room, busy;
  logic    rdy_vis, sts, sds, und_vis, flush_pend;
  logic    irq_q;
  logic    unused_wbit;

  assign unused_wbit = reg_wdata_i[7];

  always_comb begin
    cmd.commit  = reg_wr_i &  reg_wdata_i[BIT_RDY];
    cmd.flush   = reg_wr_i &  reg_wdata_i[BIT_FLU];
    cmd.clr_tog = reg_wr_i &  reg_wdata_i[BIT_CLR];
    cmd.clr_sts = reg_wr_i & ~reg_wdata_i[BIT_STS];
    cmd.clr_und = reg_wr_i & ~reg_wdata_i[BIT_UND];
    cmd.sds_wr  = reg_wr_i;
    cmd.sds_val = reg_wdata_i[BIT_SDS];
  end

  usb_in_ep_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dbl_buf_i   (dbl_buf_i),
    .commit_i    (cmd.commit),
    .sent_i      (pkt_sent_i),
    .flush_i     (flush_pend),
    .stall_i     (stall_sent_i),
    .commit_ok_o (commit_ok),
    .sent_ok_o   (sent_ok),
    .room_o      (room),
    .busy_o      (busy)
  );

  usb_in_ep_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .iso_i       (iso_mode_i),
    .hold_en_i   (iso_hold_i),
    .token_i     (in_token_i),
    .sof_i       (sof_i),
    .stall_i     (stall_sent_i),
    .commit_ok_i (commit_ok),
    .sent_ok_i   (sent_ok),
    .dbl_room_i  (dbl_buf_i & room),
    .empty_i     (~busy),
    .rdy_vis_o   (rdy_vis),
    .sts_o       (sts),
    .sds_o       (sds),
    .und_vis_o   (und_vis),
    .flush_o     (flush_pend)
  );

  usb_in_ep_toggle u_toggle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cmd.clr_tog),
    .flip_i (sent_ok & ~iso_mode_i),
    .tog_o  (data_toggle_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= sent_ok & irq_en_i;
  end

  always_comb begin
    reg_rdata_o          = '0;
    reg_rdata_o[BIT_RDY] = rdy_vis;
    reg_rdata_o[BIT_NE]  = busy;
    reg_rdata_o[BIT_UND] = und_vis;
    reg_rdata_o[BIT_FLU] = flush_pend;
    reg_rdata_o[BIT_SDS] = sds;
    reg_rdata_o[BIT_STS] = sts;
  end

  assign stall_req_o    = sds & ~iso_mode_i;
  assign flush_o        = flush_pend;
  assign fifo_ptr_rst_o = flush_pend | stall_sent_i;
  assign irq_o          = irq_q;
endmodule

// File: rtl/usb_in_ep_csr_chk.sv
`timescale 1ns/1ps
module usb_in_ep_csr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       pkt_sent_i,
  input logic       stall_sent_i,
  input logic       iso_mode_i,
  input logic       irq_en_i,
  input logic       data_toggle_o,
  input logic       stall_req_o,
  input logic       fifo_ptr_rst_o,
  input logic       irq_o
);
  p_unused_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:6] == 2'b00);

  p_clr_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_wdata_i[6] |=> !data_toggle_o);

  p_stall_effect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_sent_i |=> reg_rdata_o[5] && !reg_rdata_o[1] && !reg_rdata_o[0]);

  p_stall_ptr_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_sent_i |-> fifo_ptr_rst_o);

  p_sts_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[5] && !(reg_wr_i && !reg_wdata_i[5]) |=> reg_rdata_o[5]);

  p_iso_no_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_mode_i |-> !stall_req_o);

  p_flush_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[3] |=> !reg_rdata_o[3]);

  p_flush_ptr_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[3] |-> fifo_ptr_rst_o);

  p_und_bulk_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso_mode_i |-> !reg_rdata_o[2]);

  p_rdy_needs_pkt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[0] |-> reg_rdata_o[1]);

  p_irq_source_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(pkt_sent_i && irq_en_i));
endmodule

bind usb_in_ep_csr usb_in_ep_csr_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_wr_i       (reg_wr_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .pkt_sent_i     (pkt_sent_i),
  .stall_sent_i   (stall_sent_i),
  .iso_mode_i     (iso_mode_i),
  .irq_en_i       (irq_en_i),
  .data_toggle_o  (data_toggle_o),
  .stall_req_o    (stall_req_o),
  .fifo_ptr_rst_o (fifo_ptr_rst_o),
  .irq_o          (irq_o)
);

// File: tb/tb_usb_in_ep_csr.sv
`timescale 1ns/1ps
module tb_usb_in_ep_csr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr;
  logic [7:0] wd;
  logic [7:0] rd;
  logic       tok, sent, stl, sof;
  logic       iso, dbl, ihold, irq_en;
  logic       tog_o, sreq_o, prst_o, fl_o, irq_o;

  int vectors = 0;
  int miscompares = 0;
  string cur = "R1";

  // reference model state
  int q[$];
  int pkt_id = 0;
  bit m_rdy, m_hold, m_sts, m_sds, m_und, m_flp, m_tog, m_irq;

  always #2.5 clk = ~clk;

  usb_in_ep_csr dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .in_token_i(tok), .pkt_sent_i(sent),
    .stall_sent_i(stl), .sof_i(sof), .iso_mode_i(iso), .dbl_buf_i(dbl),
    .iso_hold_i(ihold), .irq_en_i(irq_en), .data_toggle_o(tog_o),
    .stall_req_o(sreq_o), .fifo_ptr_rst_o(prst_o), .flush_o(fl_o),
    .irq_o(irq_o)
  );

  task automatic chk(string fld, string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s [%s] actual=%b expected=%b t=%0t", req, fld, cur, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [7:0] e;
    e = '0;
    e[0] = m_rdy & ~m_hold;
    e[1] = q.size() != 0;
    e[2] = m_und & iso;
    e[3] = m_flp;
    e[4] = m_sds;
    e[5] = m_sts;
    chk("bit7", "R1", rd[7], 1'b0);
    chk("bit6", "R1", rd[6], 1'b0);
    chk("stall_sent_flag", "R3", rd[5], e[5]);
    chk("stall_bit", "R4", rd[4], e[4]);
    chk("flush_bit", "R5", rd[3], e[3]);
    chk("underrun", "R6", rd[2], e[2]);
    chk("not_empty", "R7", rd[1], e[1]);
    chk("ready", "R8", rd[0], e[0]);
    chk("toggle", "R2", tog_o, m_tog);
    chk("stall_req", "R4", sreq_o, m_sds & ~iso);
    chk("ptr_rst", "R3", prst_o, m_flp | stl);
    chk("flush_o", "R5", fl_o, m_flp);
    chk("irq", "R11", irq_o, m_irq);
  endtask

  task automatic model_edge();
    int  n, cap;
    bit  commit_ok, sent_ok, rdy_n;
    n = q.size();
    cap = dbl ? 2 : 1;
    commit_ok = wr && wd[0] && (n < cap);
    sent_ok = sent && (n > 0);
    if (stl) q.delete();
    else begin
      if (sent_ok) void'(q.pop_front());
      if (m_flp && q.size() > 0) void'(q.pop_front());
      if (commit_ok) begin q.push_back(pkt_id); pkt_id++; end
    end
    rdy_n = m_rdy;
    if (stl || sent_ok || m_flp) rdy_n = 0;
    else if (commit_ok) rdy_n = 1;
    else if (dbl && m_rdy && n < 2) rdy_n = 0;
    if (commit_ok && iso && ihold) m_hold = 1;
    else if (sof) m_hold = 0;
    m_rdy = rdy_n;
    if (stl) m_sts = 1; else if (wr && !wd[5]) m_sts = 0;
    if (wr) m_sds = wd[4];
    if (iso && tok && n == 0) m_und = 1; else if (wr && !wd[2]) m_und = 0;
    if (m_flp) m_flp = 0; else if (wr && wd[3]) m_flp = 1;
    if (wr && wd[6]) m_tog = 0; else if (sent_ok && !iso) m_tog = ~m_tog;
    m_irq = sent_ok && irq_en;
  endtask

  task automatic step(logic w, logic [7:0] d, logic t, logic s, logic st, logic f);
    @(negedge clk);
    wr = w; wd = d; tok = t; sent = s; stl = st; sof = f;
    #1 compare();
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic wreg(logic [7:0] d);
    step(1, d, 0, 0, 0, 0);
  endtask

  task automatic tx();
    step(0, 8'h00, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wr = 0; wd = 0; tok = 0; sent = 0; stl = 0; sof = 0;
    iso = 0; dbl = 0; ihold = 0; irq_en = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("reset_value", "R1", (rd == 8'h00) ? 1'b1 : 1'b0, 1'b1);
    rst_n = 1;

    // R1: idle reads zero, write to bit 7 ignored
    cur = "R1";
    idle(2);
    wreg(8'h80); idle(2);

    // R8 R9 R11 R2: single buffer commit, full commit ignored, transmit
    cur = "R8_R9_R11_R2";
    wreg(8'h01); idle(1); wreg(8'h01); wreg(8'h00); tx(); idle(2);

    // R7 R9: double buffering, early release of ready
    cur = "R7_R9";
    dbl = 1;
    wreg(8'h01); idle(1); wreg(8'h01); idle(2); wreg(8'h01);
    tx(); idle(1); tx(); idle(2);

    // R5: flush one packet per request, repeat while pending ignored
    cur = "R5";
    wreg(8'h01); idle(1); wreg(8'h01); wreg(8'h08); idle(3);
    wreg(8'h08); wreg(8'h08); idle(2); wreg(8'h08); idle(2);
    wreg(8'h01); idle(1); wreg(8'h01); step(1, 8'h08, 0, 0, 0, 0);
    step(0, 8'h00, 0, 1, 0, 0); idle(2);

    // R2: clear toggle, clear beats flip, transmit on empty ignored
    cur = "R2";
    tx(); wreg(8'h01); tx(); idle(1); wreg(8'h40); idle(1);
    wreg(8'h01); tx(); wreg(8'h01); step(1, 8'h40, 0, 1, 0, 0); idle(2);

    // R4 R3: stall request and stall handshake
    cur = "R4_R3";
    dbl = 0;
    wreg(8'h10); idle(1); wreg(8'h11); step(0, 8'h00, 0, 0, 1, 0); idle(1);
    wreg(8'h30); idle(1); wreg(8'h00); idle(1);
    iso = 1; wreg(8'h10); idle(1); iso = 0; idle(1); wreg(8'h00);

    // R12: stall set beats software clear; stall beats commit
    cur = "R12_R3";
    step(1, 8'h00, 0, 0, 1, 0); idle(1); wreg(8'h00);
    step(1, 8'h01, 0, 0, 1, 0); idle(2);

    // R6: isochronous underrun
    cur = "R6";
    iso = 1;
    step(0, 8'h00, 1, 0, 0, 0); idle(1); wreg(8'h04); wreg(8'h00);
    step(0, 8'h00, 1, 0, 0, 0); step(1, 8'h00, 1, 0, 0, 0); idle(1);
    iso = 0; idle(1); iso = 1; idle(1);
    wreg(8'h01); step(0, 8'h00, 1, 0, 0, 0); tx(); idle(1); wreg(8'h00);

    // R10: isochronous hold until start of frame
    cur = "R10";
    ihold = 1;
    wreg(8'h01); idle(3); step(0, 8'h00, 0, 0, 0, 1); idle(2); tx(); idle(1);
    ihold = 0; iso = 0;

    // R12: commit and transmit collide
    cur = "R12";
    dbl = 1;
    wreg(8'h01); idle(1); step(1, 8'h01, 0, 1, 0, 0); idle(2);
    step(1, 8'h01, 0, 1, 0, 0); idle(1); tx(); idle(1);

    // R11: interrupt gating, no interrupt from flush or stall
    cur = "R11";
    irq_en = 0; wreg(8'h01); tx(); idle(1);
    irq_en = 1; wreg(8'h01); wreg(8'h08); idle(2);
    wreg(8'h01); step(0, 8'h00, 0, 0, 1, 0); idle(1); wreg(8'h00);
    wreg(8'h01); tx(); tx(); idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule